// File: doc/BRIEF.md
# Disciplined Packet Timestamp Stamper

This block sits directly behind the receive side of an Ethernet MAC. It keeps a 64-bit time of day: 32 bits of whole seconds and 32 bits of binary fraction of a second. Every packet that streams through it is tagged with the time at which its first beat was accepted. The tag is appended as one extra beat after the packet's final data beat. Stamping happens before any receive queue, so later buffering adds no jitter to the recorded time.

The time advances through a phase accumulator. The accumulator holds the 32 fraction bits plus a configurable number of sub-fraction bits, and it adds a programmable increment word on every clock. Software retunes that word to cancel oscillator drift. A carry out of the fraction advances the seconds.

An external pulse-per-second input disciplines the count. On each rising edge of the pulse, the fraction is forced to zero. If the fraction had not yet wrapped, the seconds also step forward. The fraction value seen at that instant is latched as a signed error, so software can measure the drift and correct the increment. Several units fed by the same pulse share one time base.

Top module: `tsx_stamper`

## Requirements
- R1: After a synchronous reset the following hold:
  - the time reads zero;
  - the output stream is idle;
  - the register read data is zero until the first clock edge after reset;
  - the increment word then reads back as the parameter `NOM_INC`;
  - the error register reads zero.
- R2: On every clock edge without a pulse snap, the accumulator adds the increment word. The accumulator is `32+SUB_W` bits wide. The fraction is its top 32 bits, and a carry out of the accumulator adds one to the seconds. `tod_o` shows `{seconds, fraction}`.
- R3: A write to address 0 loads the increment word at that edge, and the new word is first added at the following edge. Read data is registered: `reg_rdata` shows the register at `reg_addr` one edge after the address is presented.
- R4: A pulse rising edge is first seen at clock edge k by the two-flop synchroniser. At edge k+2 the whole accumulator is cleared. At the same edge the seconds increase by one if fraction bit 31 was set (not yet wrapped); otherwise the seconds are unchanged.
- R5: The register at address 1 captures the pre-snap fraction at each snap, read as a 32-bit two's-complement value. It is negative when the local clock runs slow and positive when it runs fast. Writes to address 1 are ignored. Addresses 2 and 3 read zero.
- R6: A pulse held high for many cycles causes exactly one snap. Only the rising edge acts.
- R7: Data beats leave in order with their data unchanged and `m_last` low. After the final data beat comes one trailer beat with `m_last` high. The trailer carries `data[63:32]` = seconds and `data[31:0]` = fraction, and any upper bits are zero.
- R8: The trailer's time is the `tod_o` value visible during the cycle in which the packet's first beat was accepted, before that edge's update.
- R9: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data` and `m_last` hold. `s_ready` is low while a trailer is waiting to be emitted.
- R10: Under any pattern of `s_valid` and `m_ready`, no beat is lost, duplicated or invented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timestamp clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high with s_valid |
| s_data | input | DATA_W | Input beat data |
| s_last | input | 1 | Final beat of the input packet |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream accepts the output beat |
| m_data | output | DATA_W | Output beat data or trailer time |
| m_last | output | 1 | Trailer beat, ends the output packet |
| pps_in | input | 1 | Asynchronous pulse-per-second reference |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 increment, 1 pulse error) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| tod_o | output | 64 | Current time, seconds over fraction |

## Verification
The reference model in the bench drives the increment mistuned in both directions. A snap that used the wrong half of the fraction would then gain or lose a whole second. An error register with the wrong sign would push software's correction the wrong way.

A pulse held high for hundreds of cycles exposes a level-sensitive detector, which would pin the fraction at zero. An increment near the maximum forces a seconds carry every few cycles, which exposes a dropped carry.

Random stalls on both stream sides, with single-beat packets among them, catch three faults:
- a trailer stamped from the last beat instead of the first;
- a beat that changes while it is stalled;
- a new packet accepted while its predecessor's trailer is still pending.

// File: rtl/tsx_pkg.sv
package tsx_pkg;
  localparam int SEC_W  = 32;
  localparam int FRAC_W = 32;
  localparam int TOD_W  = SEC_W + FRAC_W;
  localparam int REG_AW = 2;
  localparam int REG_DW = 32;

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [FRAC_W-1:0] frac;
  } tod_t;

  typedef enum logic [REG_AW-1:0] {
    RA_INCR   = 2'd0,
    RA_PPSERR = 2'd1
  } reg_addr_e;
endpackage

// File: rtl/tsx_pps_sync.sv
module tsx_pps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pps_async,
  output logic pps_edge
);
  // chain[0..STAGES-1] resynchronise, chain[STAGES] remembers the last level
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= pps_async;
  end

  generate
    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign pps_edge = chain[STAGES-1] & ~chain[STAGES];

  // R6: a pulse edge lasts a single cycle
  a_r6_one_cycle_edge: assert property (@(posedge clk) disable iff (rst)
    pps_edge |=> !pps_edge);
endmodule

// File: rtl/tsx_tod_dds.sv
module tsx_tod_dds
  import tsx_pkg::*;
#(
  parameter int          SUB_W   = 24,
  parameter int          INC_W   = 32,
  parameter logic [31:0] NOM_INC = 32'd450359963
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pps_edge,
  input  logic                     inc_wr,
  input  logic [INC_W-1:0]         inc_wdata,
  output logic [INC_W-1:0]         inc_q,
  output tod_t                     tod,
  output logic signed [FRAC_W-1:0] pps_err
);
  localparam int ACC_W = FRAC_W + SUB_W;

  logic [ACC_W-1:0] acc_q;
  logic [SEC_W-1:0] sec_q;
  logic [ACC_W:0]   sum;
  logic [FRAC_W-1:0] frac_now;

  assign frac_now = acc_q[ACC_W-1 -: FRAC_W];
  assign sum      = {1'b0, acc_q} + (ACC_W+1)'(inc_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      sec_q   <= '0;
      inc_q   <= INC_W'(NOM_INC);
      pps_err <= '0;
    end else begin
      if (inc_wr) inc_q <= inc_wdata;
      if (pps_edge) begin
        acc_q   <= '0;
        sec_q   <= sec_q + SEC_W'(frac_now[FRAC_W-1]);
        pps_err <= $signed(frac_now);
      end else begin
        acc_q <= sum[ACC_W-1:0];
        sec_q <= sec_q + SEC_W'(sum[ACC_W]);
      end
    end
  end

  assign tod.sec  = sec_q;
  assign tod.frac = frac_now;

  // R2: seconds step by at most one per clock
  a_r2_sec_step: assert property (@(posedge clk) disable iff (rst)
    (sec_q - $past(sec_q)) <= SEC_W'(1));
  // R2: without a snap, time never runs backwards
  a_r2_forward: assert property (@(posedge clk) disable iff (rst)
    !pps_edge |=> ({sec_q, acc_q} >= $past({sec_q, acc_q})));
  // R4: a snap leaves the accumulator at zero
  a_r4_snap_clears: assert property (@(posedge clk) disable iff (rst)
    pps_edge |=> (acc_q == '0));
  // R3: a written increment is held afterwards
  a_r3_inc_load: assert property (@(posedge clk) disable iff (rst)
    inc_wr |=> (inc_q == $past(inc_wdata)));
  // R5: the error register holds the pre-snap fraction
  a_r5_err_capture: assert property (@(posedge clk) disable iff (rst)
    pps_edge |=> (pps_err == $signed($past(frac_now))));
endmodule

// File: rtl/tsx_trailer_stream.sv
module tsx_trailer_stream
  import tsx_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  tod_t              tod,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last
);
  logic              sop_q;
  logic              trail_q;
  tod_t              hold_q;
  logic              ov_q;
  logic              ol_q;
  logic [DATA_W-1:0] od_q;
  logic              slot_free;
  logic              acc_in;

  assign slot_free = !ov_q || m_ready;
  assign s_ready   = slot_free && !trail_q;
  assign acc_in    = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      sop_q   <= 1'b1;
      trail_q <= 1'b0;
      hold_q  <= '0;
      ov_q    <= 1'b0;
      ol_q    <= 1'b0;
      od_q    <= '0;
    end else begin
      if (slot_free) begin
        if (trail_q) begin
          ov_q    <= 1'b1;
          od_q    <= DATA_W'(hold_q);
          ol_q    <= 1'b1;
          trail_q <= 1'b0;
        end else if (s_valid) begin
          ov_q <= 1'b1;
          od_q <= s_data;
          ol_q <= 1'b0;
          if (s_last) trail_q <= 1'b1;
        end else begin
          ov_q <= 1'b0;
        end
      end
      if (acc_in) begin
        sop_q <= s_last;
        if (sop_q) hold_q <= tod;
      end
    end
  end

  assign m_valid = ov_q;
  assign m_data  = od_q;
  assign m_last  = ol_q;

  // R9: a stalled output beat is held
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));
  // R9: no intake while a trailer waits
  a_r9_block: assert property (@(posedge clk) disable iff (rst)
    trail_q |-> !s_ready);
  // R7: accepting a final beat schedules a trailer
  a_r7_trailer_due: assert property (@(posedge clk) disable iff (rst)
    (acc_in && s_last) |=> trail_q);
  // R8: the captured time is frozen inside a packet
  a_r8_hold_frozen: assert property (@(posedge clk) disable iff (rst)
    !sop_q |=> $stable(hold_q));
endmodule

// File: rtl/tsx_stamper.sv
module tsx_stamper
  import tsx_pkg::*;
#(
  parameter int          SUB_W       = 24,
  parameter int          INC_W       = 32,
  parameter logic [31:0] NOM_INC     = 32'd450359963,
  parameter int          DATA_W      = 64,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last,
  input  logic              pps_in,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [63:0]       tod_o
);
  logic                     pps_edge;
  logic                     inc_wr;
  logic [INC_W-1:0]         inc_q;
  logic signed [FRAC_W-1:0] pps_err;
  tod_t                     tod;

  assign inc_wr = reg_wr && (reg_addr_e'(reg_addr) == RA_INCR);

  tsx_pps_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pps_async(pps_in), .pps_edge(pps_edge)
  );

  tsx_tod_dds #(.SUB_W(SUB_W), .INC_W(INC_W), .NOM_INC(NOM_INC)) u_dds (
    .clk(clk), .rst(rst), .pps_edge(pps_edge), .inc_wr(inc_wr),
    .inc_wdata(INC_W'(reg_wdata)), .inc_q(inc_q), .tod(tod), .pps_err(pps_err)
  );

  tsx_trailer_stream #(.DATA_W(DATA_W)) u_stream (
    .clk(clk), .rst(rst), .tod(tod),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr_e'(reg_addr))
        RA_INCR:   reg_rdata <= REG_DW'(inc_q);
        RA_PPSERR: reg_rdata <= pps_err;
        default:   reg_rdata <= '0;
      endcase
    end
  end

  assign tod_o = tod;

  // R5: a write aimed at the error register leaves the increment alone
  a_r5_err_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd1) |=> $stable(inc_q));
endmodule

// File: tb/tsx_stamper_bench.sv
module tsx_stamper_bench;
  localparam int          SUBW = 4;
  localparam int          ACCW = 32 + SUBW;
  localparam logic [31:0] NOM  = 32'h1000_0000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1;
  logic        s_valid = 1'b0, s_last = 1'b0, m_ready = 1'b1;
  logic [63:0] s_data = '0;
  logic        s_ready, m_valid, m_last;
  logic [63:0] m_data, tod_o;
  logic        pps_drv = 1'b0, rw = 1'b0;
  logic [1:0]  raddr = 2'd0;
  logic [31:0] rwdata = '0, reg_rdata;

  tsx_stamper #(.SUB_W(SUBW), .INC_W(32), .NOM_INC(NOM), .DATA_W(64), .SYNC_STAGES(2)) u_tsx_stamper (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .pps_in(pps_drv), .reg_wr(rw), .reg_addr(raddr), .reg_wdata(rwdata),
    .reg_rdata(reg_rdata), .tod_o(tod_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model state
  longint unsigned m_acc;
  logic [31:0] m_sec, m_inc, m_err, exp_rd;
  logic [63:0] stamp;
  bit s1, s2, s3, m_sop;
  logic [64:0] expq[$];

  // stimulus bookkeeping
  bit acc_f = 0, trail_exp = 0, stall_f = 0, gen_on = 0, rdy_all = 1;
  logic [63:0] stall_d;
  logic stall_l;
  int pkt = 0, beat = 0, len = 3;
  string tod_tag = "R2";

  function automatic logic [31:0] mfrac();
    return 32'(m_acc >> SUBW);
  endfunction

  always @(posedge clk) begin : model
    longint unsigned sum;
    logic [31:0] fr;
    if (rst) begin
      m_acc = 0; m_sec = 0; m_inc = NOM; m_err = 0; exp_rd = 0;
      s1 = 0; s2 = 0; s3 = 0; m_sop = 1; stamp = 0; expq.delete();
    end else begin
      fr = mfrac();
      case (raddr)
        2'd0:    exp_rd = m_inc;
        2'd1:    exp_rd = m_err;
        default: exp_rd = 32'd0;
      endcase
      if (acc_f) begin
        if (m_sop) stamp = {m_sec, fr};
        expq.push_back({1'b0, s_data});
        if (s_last) expq.push_back({1'b1, stamp});
        m_sop = s_last;
      end
      if (s2 && !s3) begin
        m_err = fr;
        m_sec = m_sec + 32'(fr[31]);
        m_acc = 0;
      end else begin
        sum   = m_acc + 64'(m_inc);
        m_sec = m_sec + 32'(sum >> ACCW);
        m_acc = sum & ((64'd1 << ACCW) - 1);
      end
      if (rw && raddr == 2'd0) m_inc = rwdata;
      s3 = s2; s2 = s1; s1 = pps_drv;
    end
  end

  task automatic step();
    logic [64:0] e;
    @(negedge clk);
    if (!rst) begin
      chk(tod_o == {m_sec, mfrac()}, {tod_tag, " time of day"}, tod_o, {m_sec, mfrac()});
      chk(reg_rdata == exp_rd, "R3 R5 register read", 64'(reg_rdata), 64'(exp_rd));
      if (stall_f)
        chk(m_valid && m_data == stall_d && m_last == stall_l, "R9 stalled beat held", m_data, stall_d);
      if (trail_exp) chk(!s_ready, "R9 ready low while trailer pending", 64'(s_ready), 64'd0);
    end
    if (acc_f) begin
      if (s_last) begin pkt++; beat = 0; len = 1 + int'($urandom % 5); end
      else beat++;
    end
    if (!s_valid || acc_f) s_valid = (gen_on || beat != 0) && ($urandom % 4 != 0);
    s_data  = {32'(pkt), 32'(beat)};
    s_last  = (beat == len - 1);
    m_ready = rdy_all ? 1'b1 : ($urandom % 3 != 0);
    #1;
    acc_f     = s_valid && s_ready;
    trail_exp = acc_f && s_last;
    stall_f   = m_valid && !m_ready;
    stall_d   = m_data;
    stall_l   = m_last;
    if (m_valid && m_ready) begin
      if (expq.size() == 0) chk(1'b0, "R10 unexpected output beat", m_data, 64'd0);
      else begin
        e = expq.pop_front();
        chk(m_data == e[63:0] && m_last == e[64],
            e[64] ? "R7 R8 trailer beat time" : "R7 data beat", m_data, e[63:0]);
      end
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulse(input int high);
    pps_drv = 1'b1; run(high); pps_drv = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    run(3);
    rst = 1'b0;
    // R1 reset state, seen before the first clock after reset
    chk(tod_o == 64'd0, "R1 time after reset", tod_o, 64'd0);
    chk(!m_valid, "R1 output idle after reset", 64'(m_valid), 64'd0);
    chk(reg_rdata == 32'd0, "R1 read data after reset", 64'(reg_rdata), 64'd0);
    run(2);
    chk(reg_rdata == NOM, "R1 increment reset value", 64'(reg_rdata), 64'(NOM));

    run(300);  // R2: fraction wraps into seconds at nominal rate

    tod_tag = "R2 R3";
    rw = 1'b1; rwdata = 32'hFFFF_FFF0; step(); rw = 1'b0;
    run(100);
    chk(tod_o[63:32] > 32'd4, "R2 R3 seconds carried at fast increment", 64'(tod_o[63:32]), 64'd5);

    // R4/R5: a slow clock that has not wrapped by the pulse
    tod_tag = "R4";
    rw = 1'b1; rwdata = NOM; step(); rw = 1'b0;
    pulse(5); run(245); pulse(5);
    raddr = 2'd1; run(3);
    chk($signed(reg_rdata) < 0, "R5 slow clock gives negative error", 64'(reg_rdata), 64'd0);
    raddr = 2'd0;
    // R4/R5: a fast clock that has already wrapped
    run(260); pulse(5);
    raddr = 2'd1; run(3);
    chk($signed(reg_rdata) > 0, "R5 fast clock gives positive error", 64'(reg_rdata), 64'd1);

    // R6: a pulse held high snaps once only
    tod_tag = "R6";
    pps_drv = 1'b1; run(600); pps_drv = 1'b0;
    chk(tod_o[31:0] != 32'd0, "R6 fraction keeps running with level high", 64'(tod_o[31:0]), 64'd1);
    run(5);

    // R5: the error register ignores writes, unused addresses read zero
    tod_tag = "R5";
    raddr = 2'd1; rw = 1'b1; rwdata = 32'hDEAD_BEEF; step(); rw = 1'b0;
    run(2);
    chk(reg_rdata == m_err, "R5 write to error register ignored", 64'(reg_rdata), 64'(m_err));
    raddr = 2'd2; run(2);
    chk(reg_rdata == 32'd0, "R5 unused address reads zero", 64'(reg_rdata), 64'd0);
    raddr = 2'd0; run(2);
    chk(reg_rdata == NOM, "R5 increment untouched by error write", 64'(reg_rdata), 64'(NOM));

    // R7-R10: packet traffic, first free-flowing then with random stalls
    tod_tag = "R2";
    gen_on = 1; rdy_all = 1;
    run(300);
    rdy_all = 0;
    run(700); pulse(4); run(800);
    gen_on = 0; rdy_all = 1;
    run(60);
    chk(expq.size() == 0 && !m_valid, "R10 every beat delivered", 64'(expq.size()), 64'd0);
    chk(pkt > 20, "R7 enough packets exercised", 64'(pkt), 64'd21);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule